// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of 16-bit left/right sample pairs into a three-wire serial audio output: a bit clock, an active-low frame sync and a serial data line. Everything runs on one fast master clock; the bit clock is that master clock divided by an even, parameterised ratio. The default ratio is 34. With a 48 MHz master clock this gives a bit clock near 1.41 MHz. Each frame is 32 bit clocks, which gives a frame rate near 44.1 kHz.

An upstream producer pushes pairs with a valid/ready handshake into a small FIFO. The block pops one whole pair at the start of every frame. It sends the left word and then the right word, most-significant bit first. Data and frame sync change only as the bit clock falls, so a receiver can sample on the rising edge. A request output stays high while the FIFO holds half its depth or less, so a DMA engine or sequencer can refill it. If the FIFO is empty when a frame starts, that frame carries zeros and a sticky underrun flag is raised. A one-cycle pulse on the clear input drops the flag.

The sequencer has four states:
- `ST_IDLE` is the state after reset. It moves to `ST_LEAD` on the first falling bit-clock edge.
- `ST_LEAD` is a single lead-in bit with frame sync low. It moves to `ST_LEFT` and loads the first pair.
- `ST_LEFT` moves to `ST_RIGHT` after its 16th bit.
- `ST_RIGHT` moves back to `ST_LEFT` after its 16th bit and loads the next pair.

Top module: `stereo_i2s_tx`

## Requirements
- R1: While reset is held and right after its release, `bclk` is low, `fsync` is high, `sdata` is low, `in_ready` is high, `fifo_req` is high and `underrun` is low.
- R2: `bclk` has a period of `DIV` master-clock cycles. It is high for `DIV/2` cycles and low for `DIV/2` cycles.
- R3: A frame is 32 bit clocks: a 16-bit left slot followed by a 16-bit right slot. The first frame after reset is a left slot, preceded by exactly one lead-in bit with `fsync` low and `sdata` low.
- R4: Each word is sent most-significant bit first.
- R5: `fsync` is active low. It falls one bit clock before the left MSB and stays low for 16 bit clocks. Sampled on the rising `bclk` edges of frame bits 0..31, its pattern is low for bits 0..14, high for bits 15..30 and low for bit 31.
- R6: `sdata` and `fsync` change only in the master-clock cycle where `bclk` falls. They never change while `bclk` is high.
- R7: `fifo_req` is high exactly when the FIFO holds `FIFO_DEPTH/2` pairs or fewer.
- R8: `in_ready` is low when the FIFO is full. A pair offered while `in_ready` is low is dropped and never transmitted.
- R9: If the FIFO is empty when a frame's left slot begins, both slots of that frame carry zeros and `underrun` is set.
- R10: `underrun` stays high until a cycle with `underrun_clr` high, which clears it. If a new underrun occurs in that same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | FIFO can accept a pair |
| in_left | input | 16 | Left sample of the offered pair |
| in_right | input | 16 | Right sample of the offered pair |
| underrun_clr | input | 1 | Write-one pulse that clears the underrun flag |
| bclk | output | 1 | Divided bit clock |
| fsync | output | 1 | Frame sync, active low, marks the left slot |
| sdata | output | 1 | Serial data, MSB first |
| fifo_req | output | 1 | FIFO is at or below half full |
| underrun | output | 1 | Sticky flag for a frame started on an empty FIFO |

## Verification
The bench builds the block with `DIV=4`, `SLOT_W=16` and `FIFO_DEPTH=4`. The short divider makes one frame last 128 master cycles, so the reset lead-in, several data frames and two underrun frames all fit in a short run. A four-deep FIFO puts the half-full boundary at two pairs and the full condition at four, so the request threshold, the back-pressure on a fifth pair and the drain back into an underrun can all be reached with a handful of pushes.

// File: rtl/stereo_tx_pkg.sv
package stereo_tx_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } tx_state_e;

endpackage

// File: rtl/stx_bclk_div.sv
module stx_bclk_div #(
    parameter int DIV = 34
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic fall_tick
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt_q;
    logic          bclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else begin
            if (cnt_q == CW'(DIV - 1)) begin
                cnt_q  <= '0;
                bclk_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(HALF - 1)) begin
                    bclk_q <= 1'b1;
                end
            end
        end
    end

    // High in the master cycle whose closing edge brings bclk low
    assign fall_tick = (cnt_q == CW'(DIV - 1));
    assign bclk      = bclk_q;

endmodule

// File: rtl/stx_pair_fifo.sv
module stx_pair_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         low_half
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [NW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == NW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout     = mem[rd_q];
    assign low_half = (cnt_q <= NW'(DEPTH / 2));

endmodule

// File: rtl/stx_frame_fsm.sv
module stx_frame_fsm
    import stereo_tx_pkg::*;
#(
    parameter int SLOT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_tick,
    input  logic                fifo_empty,
    input  logic [2*SLOT_W-1:0] fifo_dout,
    output logic                pop,
    output logic                underrun_set,
    output logic                fsync,
    output logic                sdata
);
    localparam int FW = 2 * SLOT_W;
    localparam int BW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
    localparam logic [BW-1:0] LAST = BW'(SLOT_W - 1);

    tx_state_e     state_q, state_d;
    logic [BW-1:0] bit_q, bit_d;
    logic [FW-1:0] shreg_q;
    logic          fsync_q, fsync_d;
    logic          load;

    // Next-state decode, evaluated only on falling bit-clock ticks
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        load    = 1'b0;
        if (fall_tick) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_LEAD;
                ST_LEAD: begin
                    state_d = ST_LEFT;
                    bit_d   = '0;
                    load    = 1'b1;
                end
                ST_LEFT: begin
                    if (bit_q == LAST) begin
                        state_d = ST_RIGHT;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (bit_q == LAST) begin
                        state_d = ST_LEFT;
                        bit_d   = '0;
                        load    = 1'b1;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Sync level for the bit being entered: low from the lead bit through
    // left bit SLOT_W-2, and again on the last right bit
    always_comb begin
        unique case (state_d)
            ST_IDLE:  fsync_d = 1'b1;
            ST_LEAD:  fsync_d = 1'b0;
            ST_LEFT:  fsync_d = (bit_d == LAST);
            ST_RIGHT: fsync_d = (bit_d != LAST);
        endcase
    end

    assign pop          = load && !fifo_empty;
    assign underrun_set = load && fifo_empty;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // Output register: sync and data move together with the bclk fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_q <= 1'b1;
            shreg_q <= '0;
        end else if (fall_tick) begin
            fsync_q <= fsync_d;
            if (load) begin
                shreg_q <= fifo_empty ? '0 : fifo_dout;
            end else if (state_q == ST_LEFT || state_q == ST_RIGHT) begin
                shreg_q <= {shreg_q[FW-2:0], 1'b0};
            end
        end
    end

    assign fsync = fsync_q;
    assign sdata = shreg_q[FW-1];

endmodule

// File: rtl/stereo_i2s_tx.sv
module stereo_i2s_tx #(
    parameter int DIV        = 34,
    parameter int SLOT_W     = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SLOT_W-1:0] in_left,
    input  logic [SLOT_W-1:0] in_right,
    input  logic              underrun_clr,
    output logic              bclk,
    output logic              fsync,
    output logic              sdata,
    output logic              fifo_req,
    output logic              underrun
);
    localparam int PAIR_W = 2 * SLOT_W;

    logic              fall_tick;
    logic              f_full, f_empty, f_low, f_pop;
    logic [PAIR_W-1:0] f_dout;
    logic              ur_set, ur_q;

    stx_bclk_div #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .fall_tick (fall_tick)
    );

    stx_pair_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (in_valid && !f_full),
        .din      ({in_left, in_right}),
        .pop      (f_pop),
        .dout     (f_dout),
        .full     (f_full),
        .empty    (f_empty),
        .low_half (f_low)
    );

    stx_frame_fsm #(.SLOT_W(SLOT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_tick    (fall_tick),
        .fifo_empty   (f_empty),
        .fifo_dout    (f_dout),
        .pop          (f_pop),
        .underrun_set (ur_set),
        .fsync        (fsync),
        .sdata        (sdata)
    );

    // Sticky underrun flag; a new underrun beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ur_q <= 1'b0;
        end else if (ur_set) begin
            ur_q <= 1'b1;
        end else if (underrun_clr) begin
            ur_q <= 1'b0;
        end
    end

    assign in_ready = !f_full;
    assign fifo_req = f_low;
    assign underrun = ur_q;

endmodule

// File: rtl/stereo_tx_checker.sv
module stereo_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic underrun_clr,
    input logic bclk,
    input logic fsync,
    input logic sdata,
    input logic fifo_req,
    input logic underrun
);
    a_r6_fsync_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsync) |-> $fell(bclk));

    a_r6_sdata_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun);

    a_r7_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !fifo_req);

    a_r2_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |=> bclk);

    a_r2_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |=> !bclk);
endmodule

bind stereo_i2s_tx stereo_tx_checker u_chk (.*);

// File: tb/stereo_i2s_tx_bench.sv
`timescale 1ns/1ps
module stereo_i2s_tx_bench;
    localparam int DIV = 4;
    localparam int SW  = 16;
    localparam int DEP = 4;
    localparam logic [31:0] FS_PAT = 32'h7FFF_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [SW-1:0] in_left = '0, in_right = '0;
    logic underrun_clr = 1'b0;
    logic in_ready, bclk, fsync, sdata, fifo_req, underrun;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stereo_i2s_tx #(.DIV(DIV), .SLOT_W(SW), .FIFO_DEPTH(DEP)) u_stereo_i2s_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .underrun_clr(underrun_clr),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .fifo_req(fifo_req),
        .underrun(underrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Receiver model: samples on rising bclk, frames on the fsync fall
    logic [SW-1:0] cap_l [0:63];
    logic [SW-1:0] cap_r [0:63];
    logic [31:0]   cap_fs [0:63];
    int frame_cnt = 0;
    int lead_seen = 0;
    int lead_data = 0;
    int mid_high_changes = 0;

    initial begin
        logic prev_b, prev_fs, last_d, last_f;
        logic [31:0] word, pat;
        int pos;
        prev_b = 1'b0; prev_fs = 1'b1; last_d = 1'b0; last_f = 1'b1;
        pos = -1; word = '0; pat = '0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (bclk && !prev_b) begin
                last_d = sdata; last_f = fsync;
                if (pos < 0) begin
                    if (prev_fs && !fsync) begin
                        lead_seen++;
                        if (sdata !== 1'b0) lead_data++;
                        pos = 0;
                    end
                end else begin
                    word = {word[30:0], sdata};
                    pat[pos] = fsync;
                    pos++;
                    if (pos == 32) begin
                        if (frame_cnt < 64) begin
                            cap_l[frame_cnt]  = word[31:16];
                            cap_r[frame_cnt]  = word[15:0];
                            cap_fs[frame_cnt] = pat;
                        end
                        frame_cnt++;
                        pos = 0;
                    end
                end
                prev_fs = fsync;
            end else if (bclk && prev_b) begin
                if (sdata !== last_d || fsync !== last_f) mid_high_changes++;
            end
            prev_b = bclk;
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 bclk", {31'd0, bclk}, 32'd0);
        chk("R1 fsync", {31'd0, fsync}, 32'd1);
        chk("R1 sdata", {31'd0, sdata}, 32'd0);
        chk("R1 ready/req", {30'd0, in_ready, fifo_req}, 32'd3);
        chk("R1 underrun", {31'd0, underrun}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {28'd0, bclk, fsync, sdata, underrun}, 32'b0100);
    endtask

    task automatic t_divider();
        int hi, lo;
        hi = 0; lo = 0;
        while (!bclk) @(negedge clk);
        while (bclk) begin hi++; @(negedge clk); end
        while (!bclk) begin lo++; @(negedge clk); end
        chk("R2 high cycles", hi, DIV / 2);
        chk("R2 low cycles", lo, DIV / 2);
        chk("R2 period", hi + lo, DIV);
    endtask

    task automatic t_underrun_start();
        wait (frame_cnt >= 1);
        chk("R3 one lead bit, low data", {lead_seen[15:0], lead_data[15:0]}, {16'd1, 16'd0});
        chk("R9 zero frame", {cap_l[0], cap_r[0]}, 32'd0);
        chk("R5 fsync pattern frame0", cap_fs[0], FS_PAT);
        chk("R9 underrun set", {31'd0, underrun}, 32'd1);
        repeat (8 * DIV) @(negedge clk);
        chk("R10 still sticky", {31'd0, underrun}, 32'd1);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk("R10 cleared", {31'd0, underrun}, 32'd0);
    endtask

    task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_fill_and_stream();
        int base;
        base = frame_cnt + 1;
        push(16'hA55A, 16'h0F0F);
        push(16'h8001, 16'h7FFE);
        chk("R7 req at half", {31'd0, fifo_req}, 32'd1);
        push(16'hFFFF, 16'h0000);
        chk("R7 no req above half", {31'd0, fifo_req}, 32'd0);
        push(16'h1234, 16'hC3E1);
        chk("R8 full not ready", {31'd0, in_ready}, 32'd0);
        push(16'hDEAD, 16'hBEEF);
        chk("R8 still full after refused offer", {31'd0, in_ready}, 32'd0);

        wait (frame_cnt >= base + 1);
        chk("R4 frame P0", {cap_l[base], cap_r[base]}, 32'hA55A_0F0F);
        chk("R7 three held", {30'd0, in_ready, fifo_req}, 32'b10);
        chk("R10 no underrun with data", {31'd0, underrun}, 32'd0);
        wait (frame_cnt >= base + 2);
        chk("R4 frame P1", {cap_l[base+1], cap_r[base+1]}, 32'h8001_7FFE);
        chk("R7 req back at two", {31'd0, fifo_req}, 32'd1);
        wait (frame_cnt >= base + 4);
        chk("R3 frame P2", {cap_l[base+2], cap_r[base+2]}, 32'hFFFF_0000);
        chk("R3 frame P3", {cap_l[base+3], cap_r[base+3]}, 32'h1234_C3E1);
        chk("R5 fsync pattern data frame", cap_fs[base+3], FS_PAT);
        wait (frame_cnt >= base + 5);
        chk("R8 refused pair not sent", {cap_l[base+4], cap_r[base+4]}, 32'd0);
        chk("R9 underrun after drain", {31'd0, underrun}, 32'd1);
        chk("R6 no change while bclk high", mid_high_changes, 0);
    endtask

    initial begin
        t_reset();
        t_divider();
        t_underrun_start();
        t_fill_and_stream();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule